// File: doc/BRIEF.md
# Stack Pointer, Status Word and Register-Bank Unit

This block holds the processor-state registers of a small 8-bit accumulator core: an 8-bit stack pointer, the program status word, and a 16-bit data pointer. The core's sequencer drives four one-cycle stack strobes: push, pop, call and return. The block turns each strobe into an internal-RAM address and a write or read strobe for the stack. It also maps a register number R0..R7 to a physical RAM address through the two bank-select bits of the status word. Its parity flag follows the accumulator every cycle.

The stack side is a request path toward RAM. That RAM is assumed to accept one access in every cycle, so the block applies no back-pressure toward RAM. Back-pressure toward the sequencer is `busy_o`. A call stores two bytes and a return reads two bytes, so each occupies two cycles. In the second cycle `busy_o` is high, and every stack strobe and stack-pointer write presented in that cycle is dropped. The sequencer must hold or re-issue such requests itself. Status-word and data-pointer writes are plain control inputs and are never blocked.

Top module: `proc_state_unit`

## Requirements
- R1: While reset is held and after reset is released, the stack pointer reads 07H, the status word reads 00H, the data pointer reads 0000H and `busy_o` is low.
- R2: A push increments the pointer before the store. In the strobe cycle, `stk_addr_o` is the pointer plus one and `stk_we_o` is high with `stk_wdata_o` = `push_data_i`. From the next cycle the pointer holds that address, so the first push after reset stores at 08H.
- R3: A pop reads before the decrement. In the strobe cycle, `stk_re_o` is high and `stk_addr_o` equals the current pointer. The pointer is one less from the next cycle.
- R4: A call stores the 16-bit `ret_addr_i` as two pushes. The low byte is written at pointer+1 in the strobe cycle. The high byte is written at pointer+2 in the following cycle, with `busy_o` high. After that, the pointer has advanced by two.
- R5: A return reads two bytes, high byte first. It reads at the pointer in the strobe cycle and at pointer-1 in the following cycle, with `busy_o` high. After that, the pointer has dropped by two.
- R6: The pointer wraps from FFH to 00H on increment and from 00H to FFH on decrement, with no error indication.
- R7: When several strobes arrive together, call wins over return, return over push, and push over pop. Only the winner takes effect. While `busy_o` is high, all strobes and any pointer write are ignored, and `stk_we_o` and `stk_re_o` are never both high.
- R8: `reg_addr_o` = {000b, status bit 4, status bit 3, `reg_num_i`}. Bank 0 therefore covers 00H-07H, bank 1 covers 08H-0FH, bank 2 covers 10H-17H and bank 3 covers 18H-1FH.
- R9: Status bit 0 holds the odd parity of `acc_i` sampled at the previous clock edge: 1 when that value had an odd number of ones. A status write never changes it.
- R10: A status write loads `psw_wdata_i` into status bits 7..1 from the next cycle. From bit 7 down, those bits are carry, auxiliary carry, user flag, bank-select high, bank-select low, overflow and spare flag.
- R11: A full write loads all 16 data-pointer bits from `dptr_wdata_i`. Otherwise the low-byte and high-byte writes each load `dbyte_i` into their own byte only. A full write wins over byte writes in the same cycle.
- R12: When the block is not busy and no stack strobe is present, a pointer write loads `sp_wdata_i` into the stack pointer from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| push_data_i | input | 8 | Byte stored by a push |
| ret_addr_i | input | 16 | Return address stored by a call |
| sp_we_i | input | 1 | Direct stack-pointer write |
| sp_wdata_i | input | 8 | New stack-pointer value |
| sp_o | output | 8 | Stack pointer |
| stk_addr_o | output | 8 | RAM address of the stack access |
| stk_we_o | output | 1 | Stack write strobe |
| stk_wdata_o | output | 8 | Stack write data |
| stk_re_o | output | 1 | Stack read strobe |
| busy_o | output | 1 | Second beat of a call or return; strobes are ignored |
| psw_we_i | input | 1 | Status-word write |
| psw_wdata_i | input | 7 | New status bits 7..1 |
| acc_i | input | 8 | Accumulator value for parity |
| psw_o | output | 8 | Status word |
| reg_num_i | input | 3 | Register number R0..R7 |
| reg_addr_o | output | 8 | Physical RAM address of that register |
| dptr_we_i | input | 1 | Full 16-bit data-pointer write |
| dptr_wdata_i | input | 16 | Full data-pointer value |
| dpl_we_i | input | 1 | Low-byte data-pointer write |
| dph_we_i | input | 1 | High-byte data-pointer write |
| dbyte_i | input | 8 | Byte for the byte writes |
| dptr_o | output | 16 | Data pointer |

## Verification
The stack address, the stack write and read strobes, the write data and the register address are combinational. They are due in the same cycle as the strobe or the bank bits that cause them. The stack pointer, status bits, data pointer and `busy_o` change at the first clock edge after a request. Parity trails the accumulator by exactly one edge, and the second beat of a call or return is due one cycle after its strobe. Inputs are driven just after a rising edge, and a behavioural model advances at each rising edge. Every output is compared with that model at the falling edge, so combinational results are read in their own cycle and registered results one edge later.

// File: rtl/cstate_pkg.sv
package cstate_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_CALL_HI = 2'd1,
    PH_RET_LO  = 2'd2
  } stk_phase_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4
  } stk_op_e;
endpackage

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import cstate_pkg::*;
#(
  parameter int W       = 8,
  parameter int SP_INIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic [W-1:0]     push_data_i,
  input  logic [2*W-1:0]   ret_addr_i,
  input  logic             sp_we_i,
  input  logic [W-1:0]     sp_wdata_i,
  output logic [W-1:0]     sp_o,
  output logic [W-1:0]     addr_o,
  output logic             we_o,
  output logic [W-1:0]     wdata_o,
  output logic             re_o,
  output logic             busy_o
);
  localparam int RW = 2 * W;
  localparam logic [W-1:0] SP_RST = W'(SP_INIT);
  localparam logic [W-1:0] ONE    = W'(1);

  stk_phase_e ph_q, ph_d;
  stk_op_e    op;
  logic [W-1:0] sp_q, sp_d, hold_q, hold_d, sp_inc, sp_dec;

  assign sp_inc = sp_q + ONE;
  assign sp_dec = sp_q - ONE;

  // fixed priority among strobes; nothing is accepted in the second beat
  always_comb begin
    op = OP_NONE;
    if (ph_q == PH_IDLE) begin
      if (call_i)      op = OP_CALL;
      else if (ret_i)  op = OP_RET;
      else if (push_i) op = OP_PUSH;
      else if (pop_i)  op = OP_POP;
    end
  end

  always_comb begin
    ph_d    = ph_q;
    sp_d    = sp_q;
    hold_d  = hold_q;
    addr_o  = sp_q;
    we_o    = 1'b0;
    re_o    = 1'b0;
    wdata_o = push_data_i;
    case (ph_q)
      PH_CALL_HI: begin
        we_o    = 1'b1;
        addr_o  = sp_inc;
        wdata_o = hold_q;
        sp_d    = sp_inc;
        ph_d    = PH_IDLE;
      end
      PH_RET_LO: begin
        re_o = 1'b1;
        sp_d = sp_dec;
        ph_d = PH_IDLE;
      end
      default: begin
        case (op)
          OP_CALL: begin
            we_o    = 1'b1;
            addr_o  = sp_inc;
            wdata_o = ret_addr_i[W-1:0];
            hold_d  = ret_addr_i[RW-1:W];
            sp_d    = sp_inc;
            ph_d    = PH_CALL_HI;
          end
          OP_RET: begin
            re_o = 1'b1;
            sp_d = sp_dec;
            ph_d = PH_RET_LO;
          end
          OP_PUSH: begin
            we_o   = 1'b1;
            addr_o = sp_inc;
            sp_d   = sp_inc;
          end
          OP_POP: begin
            re_o = 1'b1;
            sp_d = sp_dec;
          end
          default: begin
            if (sp_we_i) sp_d = sp_wdata_i;
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      sp_q   <= SP_RST;
      hold_q <= '0;
    end else begin
      ph_q   <= ph_d;
      sp_q   <= sp_d;
      hold_q <= hold_d;
    end
  end

  assign sp_o   = sp_q;
  assign busy_o = (ph_q != PH_IDLE);

  // R2: pointer advances after a lone push
  a_r2_push_preinc: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && push_i && !call_i && !ret_i) |=> (sp_q == $past(sp_q) + ONE));

  // R3: pointer drops after a lone pop
  a_r3_pop_postdec: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && pop_i && !push_i && !call_i && !ret_i) |=> (sp_q == $past(sp_q) - ONE));

  // R4: second beat of a call stores the high byte
  a_r4_call_high_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && call_i) |=> (busy_o && we_o && wdata_o == $past(ret_addr_i[RW-1:W])));

  // R5: second beat of a return reads one below the first address
  a_r5_ret_low_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && ret_i && !call_i) |=> (busy_o && re_o && addr_o == $past(addr_o) - ONE));

  // R7: busy lasts one cycle, and read and write never coincide
  a_r7_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !busy_o);
  a_r7_no_rw_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_o && re_o));
endmodule

// File: rtl/status_word_unit.sv
module status_word_unit #(
  parameter int W        = 8,
  parameter int REGS_LOG = 3,
  parameter int BANK_LSB = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_i,
  input  logic [W-1:1]        wdata_i,
  input  logic [W-1:0]        acc_i,
  input  logic [REGS_LOG-1:0] reg_num_i,
  output logic [W-1:0]        psw_o,
  output logic [W-1:0]        reg_addr_o
);
  localparam int PAD = W - 2 - REGS_LOG;

  logic [W-1:1] flags_q;
  logic         par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      par_q   <= 1'b0;
    end else begin
      if (we_i) flags_q <= wdata_i;
      par_q <= ^acc_i;
    end
  end

  assign psw_o      = {flags_q, par_q};
  assign reg_addr_o = {{PAD{1'b0}}, flags_q[BANK_LSB+1:BANK_LSB], reg_num_i};

  // R9: parity trails the accumulator by one edge
  a_r9_parity_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (psw_o[0] == $past(^acc_i)));

  // R10: written flags appear next cycle
  a_r10_flag_write: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (psw_o[W-1:1] == $past(wdata_i)));

  // R8: bank field of the register address follows a status write
  a_r8_bank_follow: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (reg_addr_o[REGS_LOG+1:REGS_LOG] == $past(wdata_i[BANK_LSB+1:BANK_LSB])));
endmodule

// File: rtl/data_ptr_unit.sv
module data_ptr_unit #(
  parameter int W = 16,
  parameter int B = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full_we_i,
  input  logic [W-1:0]     full_wdata_i,
  input  logic [W/B-1:0]   lane_we_i,
  input  logic [B-1:0]     lane_data_i,
  output logic [W-1:0]     dptr_o
);
  localparam int LANES = W / B;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [B-1:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             lane_q <= '0;
      else if (full_we_i)     lane_q <= full_wdata_i[g*B +: B];
      else if (lane_we_i[g])  lane_q <= lane_data_i;
    end
    assign dptr_o[g*B +: B] = lane_q;
  end

  // R11: full write loads every bit
  a_r11_full_write: assert property (@(posedge clk) disable iff (!rst_n)
    full_we_i |=> (dptr_o == $past(full_wdata_i)));

  // R11: low-byte write leaves it in lane 0 only when no full write
  a_r11_lane0_write: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we_i[0] && !full_we_i) |=> (dptr_o[B-1:0] == $past(lane_data_i)));
endmodule

// File: rtl/proc_state_unit.sv
module proc_state_unit #(
  parameter int W        = 8,
  parameter int SP_INIT  = 7,
  parameter int REGS_LOG = 3,
  parameter int BANK_LSB = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_i,
  input  logic                pop_i,
  input  logic                call_i,
  input  logic                ret_i,
  input  logic [W-1:0]        push_data_i,
  input  logic [2*W-1:0]      ret_addr_i,
  input  logic                sp_we_i,
  input  logic [W-1:0]        sp_wdata_i,
  output logic [W-1:0]        sp_o,
  output logic [W-1:0]        stk_addr_o,
  output logic                stk_we_o,
  output logic [W-1:0]        stk_wdata_o,
  output logic                stk_re_o,
  output logic                busy_o,
  input  logic                psw_we_i,
  input  logic [W-1:1]        psw_wdata_i,
  input  logic [W-1:0]        acc_i,
  output logic [W-1:0]        psw_o,
  input  logic [REGS_LOG-1:0] reg_num_i,
  output logic [W-1:0]        reg_addr_o,
  input  logic                dptr_we_i,
  input  logic [2*W-1:0]      dptr_wdata_i,
  input  logic                dpl_we_i,
  input  logic                dph_we_i,
  input  logic [W-1:0]        dbyte_i,
  output logic [2*W-1:0]      dptr_o
);
  localparam int DW = 2 * W;

  stack_ptr_unit #(.W(W), .SP_INIT(SP_INIT)) i_stack (
    .clk(clk), .rst_n(rst_n),
    .push_i(push_i), .pop_i(pop_i), .call_i(call_i), .ret_i(ret_i),
    .push_data_i(push_data_i), .ret_addr_i(ret_addr_i),
    .sp_we_i(sp_we_i), .sp_wdata_i(sp_wdata_i),
    .sp_o(sp_o), .addr_o(stk_addr_o), .we_o(stk_we_o),
    .wdata_o(stk_wdata_o), .re_o(stk_re_o), .busy_o(busy_o)
  );

  status_word_unit #(.W(W), .REGS_LOG(REGS_LOG), .BANK_LSB(BANK_LSB)) i_status (
    .clk(clk), .rst_n(rst_n),
    .we_i(psw_we_i), .wdata_i(psw_wdata_i), .acc_i(acc_i),
    .reg_num_i(reg_num_i), .psw_o(psw_o), .reg_addr_o(reg_addr_o)
  );

  data_ptr_unit #(.W(DW), .B(W)) i_dptr (
    .clk(clk), .rst_n(rst_n),
    .full_we_i(dptr_we_i), .full_wdata_i(dptr_wdata_i),
    .lane_we_i({dph_we_i, dpl_we_i}), .lane_data_i(dbyte_i),
    .dptr_o(dptr_o)
  );
endmodule

// File: tb/test_proc_state_unit.sv
`timescale 1ns/1ps
module test_proc_state_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic push_i, pop_i, call_i, ret_i, sp_we_i, psw_we_i, dptr_we_i, dpl_we_i, dph_we_i;
  logic [7:0]  push_data_i, sp_wdata_i, acc_i, dbyte_i;
  logic [15:0] ret_addr_i, dptr_wdata_i;
  logic [7:1]  psw_wdata_i;
  logic [2:0]  reg_num_i;
  logic [7:0]  sp_o, stk_addr_o, stk_wdata_o, psw_o, reg_addr_o;
  logic        stk_we_o, stk_re_o, busy_o;
  logic [15:0] dptr_o;

  proc_state_unit i_proc_state_unit (
    .clk(clk), .rst_n(rst_n),
    .push_i(push_i), .pop_i(pop_i), .call_i(call_i), .ret_i(ret_i),
    .push_data_i(push_data_i), .ret_addr_i(ret_addr_i),
    .sp_we_i(sp_we_i), .sp_wdata_i(sp_wdata_i), .sp_o(sp_o),
    .stk_addr_o(stk_addr_o), .stk_we_o(stk_we_o), .stk_wdata_o(stk_wdata_o),
    .stk_re_o(stk_re_o), .busy_o(busy_o),
    .psw_we_i(psw_we_i), .psw_wdata_i(psw_wdata_i), .acc_i(acc_i), .psw_o(psw_o),
    .reg_num_i(reg_num_i), .reg_addr_o(reg_addr_o),
    .dptr_we_i(dptr_we_i), .dptr_wdata_i(dptr_wdata_i),
    .dpl_we_i(dpl_we_i), .dph_we_i(dph_we_i), .dbyte_i(dbyte_i), .dptr_o(dptr_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference state
  logic [7:0]  m_sp, m_hold;
  int          m_ph;
  logic [7:1]  m_flags;
  logic        m_par;
  logic [15:0] m_dp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sp = 8'h07; m_hold = 8'h00; m_ph = 0; m_flags = '0; m_par = 1'b0; m_dp = 16'h0;
    end else begin
      if (m_ph == 1)      begin m_sp = m_sp + 8'd1; m_ph = 0; end
      else if (m_ph == 2) begin m_sp = m_sp - 8'd1; m_ph = 0; end
      else if (call_i)    begin m_sp = m_sp + 8'd1; m_hold = ret_addr_i[15:8]; m_ph = 1; end
      else if (ret_i)     begin m_sp = m_sp - 8'd1; m_ph = 2; end
      else if (push_i)    m_sp = m_sp + 8'd1;
      else if (pop_i)     m_sp = m_sp - 8'd1;
      else if (sp_we_i)   m_sp = sp_wdata_i;
      if (psw_we_i) m_flags = psw_wdata_i;
      m_par = ^acc_i;
      if (dptr_we_i) m_dp = dptr_wdata_i;
      else begin
        if (dpl_we_i) m_dp[7:0]  = dbyte_i;
        if (dph_we_i) m_dp[15:8] = dbyte_i;
      end
    end
  end

  // compare every output at the falling edge
  always @(negedge clk) begin : cmp
    string rq;
    logic [7:0] ea, ewd;
    logic ewe, ere;
    if (rst_n && !done) begin
      ewe = 1'b0; ere = 1'b0; ea = m_sp; ewd = push_data_i; rq = "R12";
      if (m_ph == 1)      begin rq = "R4"; ewe = 1'b1; ea = m_sp + 8'd1; ewd = m_hold; end
      else if (m_ph == 2) begin rq = "R5"; ere = 1'b1; end
      else if (call_i)    begin rq = "R4"; ewe = 1'b1; ea = m_sp + 8'd1; ewd = ret_addr_i[7:0]; end
      else if (ret_i)     begin rq = "R5"; ere = 1'b1; end
      else if (push_i)    begin rq = "R2"; ewe = 1'b1; ea = m_sp + 8'd1; end
      else if (pop_i)     begin rq = "R3"; ere = 1'b1; end
      if (m_ph != 0 && (call_i || ret_i || push_i || pop_i || sp_we_i)) rq = "R7";
      chk(rq, "sp_o", sp_o, m_sp);
      chk(rq, "busy_o", busy_o, (m_ph != 0));
      chk(rq, "stk_we_o", stk_we_o, ewe);
      chk(rq, "stk_re_o", stk_re_o, ere);
      if (ewe || ere) chk(rq, "stk_addr_o", stk_addr_o, ea);
      if (ewe) chk(rq, "stk_wdata_o", stk_wdata_o, ewd);
      chk("R10", "psw flags", psw_o[7:1], m_flags);
      chk("R9", "parity", psw_o[0], m_par);
      chk("R8", "reg_addr_o", reg_addr_o, {3'b000, m_flags[4:3], reg_num_i});
      chk("R11", "dptr_o", dptr_o, m_dp);
    end
  end

  task automatic idle_inputs();
    push_i = 0; pop_i = 0; call_i = 0; ret_i = 0; sp_we_i = 0; psw_we_i = 0;
    dptr_we_i = 0; dpl_we_i = 0; dph_we_i = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle_inputs();
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin : stim
    idle_inputs();
    push_data_i = 0; sp_wdata_i = 0; acc_i = 0; dbyte_i = 0; ret_addr_i = 0;
    dptr_wdata_i = 0; psw_wdata_i = 0; reg_num_i = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "sp in reset", sp_o, 8'h07);
    chk("R1", "psw in reset", psw_o, 8'h00);
    chk("R1", "dptr in reset", dptr_o, 16'h0);
    chk("R1", "busy in reset", busy_o, 0);
    rst_n = 1'b1;
    tick();
    chk("R1", "sp after reset", sp_o, 8'h07);

    // R2: first push lands at 08H
    push_i = 1; push_data_i = 8'hA5;
    #1 chk("R2", "first push addr", stk_addr_o, 8'h08);
    tick();
    chk("R2", "sp after push", sp_o, 8'h08);
    pop_i = 1;
    #1 chk("R3", "pop addr", stk_addr_o, 8'h08);
    tick();
    chk("R3", "sp after pop", sp_o, 8'h07);

    // R6: wrap both directions
    sp_we_i = 1; sp_wdata_i = 8'hFF; tick();
    chk("R12", "sp direct write", sp_o, 8'hFF);
    push_i = 1; #1 chk("R6", "push addr at wrap", stk_addr_o, 8'h00);
    tick();
    chk("R6", "sp wrapped up", sp_o, 8'h00);
    pop_i = 1; tick();
    chk("R6", "sp wrapped down", sp_o, 8'hFF);

    // R4 / R7: call with strobes during the busy beat
    sp_we_i = 1; sp_wdata_i = 8'h20; tick();
    call_i = 1; push_i = 1; ret_addr_i = 16'h1234;
    #1 chk("R7", "call beats push", stk_wdata_o, 8'h34);
    tick();
    push_i = 1; pop_i = 1; sp_we_i = 1; sp_wdata_i = 8'h55;
    #1 chk("R4", "high byte", stk_wdata_o, 8'h12);
    chk("R4", "high addr", stk_addr_o, 8'h22);
    tick();
    chk("R7", "sp after call ignoring strobes", sp_o, 8'h22);

    // R5: return
    ret_i = 1; pop_i = 1; tick();
    #1 chk("R5", "low byte addr", stk_addr_o, 8'h21);
    tick();
    chk("R5", "sp after ret", sp_o, 8'h20);

    // R8 / R10: walk the four banks
    for (int b = 0; b < 4; b++) begin
      psw_we_i = 1; psw_wdata_i = 7'(b << 2) | 7'h41; tick();
      for (int r = 0; r < 8; r++) begin
        reg_num_i = 3'(r); #1;
        chk("R8", "bank map", reg_addr_o, b * 8 + r);
      end
    end

    // R9: parity ignores written bit, follows acc
    acc_i = 8'h07; tick();
    chk("R9", "odd acc", psw_o[0], 1);
    acc_i = 8'h03; psw_we_i = 1; psw_wdata_i = 7'h7F; tick();
    chk("R9", "even acc", psw_o[0], 0);
    chk("R10", "all flags set", psw_o[7:1], 7'h7F);

    // R11: data pointer forms
    dptr_we_i = 1; dptr_wdata_i = 16'hBEEF; tick();
    chk("R11", "full write", dptr_o, 16'hBEEF);
    dpl_we_i = 1; dbyte_i = 8'h11; tick();
    chk("R11", "low byte", dptr_o, 16'hBE11);
    dph_we_i = 1; dbyte_i = 8'h22; tick();
    chk("R11", "high byte", dptr_o, 16'h2211);
    dptr_we_i = 1; dptr_wdata_i = 16'h0F0F; dpl_we_i = 1; dph_we_i = 1; dbyte_i = 8'hCC; tick();
    chk("R11", "full wins", dptr_o, 16'h0F0F);

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      push_i = ($urandom % 5) == 0;
      pop_i  = ($urandom % 5) == 0;
      call_i = ($urandom % 9) == 0;
      ret_i  = ($urandom % 9) == 0;
      sp_we_i = ($urandom % 11) == 0;
      psw_we_i = ($urandom % 7) == 0;
      dptr_we_i = ($urandom % 8) == 0;
      dpl_we_i = ($urandom % 6) == 0;
      dph_we_i = ($urandom % 6) == 0;
      push_data_i = 8'($urandom); sp_wdata_i = 8'($urandom); acc_i = 8'($urandom);
      dbyte_i = 8'($urandom); ret_addr_i = 16'($urandom); dptr_wdata_i = 16'($urandom);
      psw_wdata_i = 7'($urandom); reg_num_i = 3'($urandom);
      tick();
    end
    tick();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule